// File: doc/BRIEF.md
# Four-Phase Stepper Coil Sequencer

This block drives the four coil lines of a unipolar four-phase stepper motor. An external step-rate clock sets the speed: on each rising edge of that clock, while the enable input is high, the sequencer moves one position along the energizing pattern. The pattern depends on two level inputs. A direction input selects forward or reverse rotation. A mode input selects the half-step pattern, which has eight positions and alternates one and two energized coils, or the full-step pattern, which uses only the four single-coil positions.

The controller has nine states. One state leaves every coil off, and the other eight are the energized positions of the half-step cycle. Reset puts the controller in the all-off state. The first enabled edge after that picks an entry position from the direction: coil A for forward and coil D for reverse. The coil word passes through a register clocked by the step clock before it leaves the block, so the pins change only at clock edges and never glitch.

Top module: `step_sequencer`

## Requirements
- R1: A high `rst` sampled on a rising `step_clk` edge moves the controller to the all-off state. On the edge after that one, `coil` reads 4'b0000.
- R2: While `enable` is 0, a rising edge leaves the position unchanged, so `coil` keeps showing the same pattern.
- R3: With `half_step`=1 and `reverse`=0, the positions run forward as A, AB, B, BC, C, CD, D, DA and then wrap back to A. The entry position from all-off is A.
- R4: With `half_step`=1 and `reverse`=1, the same cycle runs backward and wraps from A to DA. The entry position from all-off is D.
- R5: With `half_step`=0, the controller visits only the single-coil positions. Forward runs A, B, C, D and wraps. Reverse runs D, C, B, A and wraps. The entry position from all-off is A for forward and D for reverse.
- R6: If `half_step` drops to 0 while the controller is at a two-coil position, the next enabled edge moves it to the adjacent single-coil position in the current direction. For example, AB goes to B when forward and to A when reverse.
- R7: If `reverse` changes during a run, the next step is taken from the current position in the new direction, and the controller does not pass through all-off.
- R8: `coil` maps bit 3 to A, bit 2 to B, bit 1 to C and bit 0 to D, and a 1 energizes a coil. `coil` is a register on `step_clk`, so it shows the position that was current just before the most recent edge. The result is one edge of lag.
- R9: `coil` never has more than two bits set, and two bits are set only for neighbouring coils, with D and A counted as neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| step_clk | input | 1 | Step-rate clock. Each rising edge is one possible step |
| rst | input | 1 | Synchronous active-high reset to the all-off state |
| enable | input | 1 | Allows stepping when high |
| half_step | input | 1 | 1 selects the eight-position pattern, 0 selects the four-position pattern |
| reverse | input | 1 | 1 selects reverse rotation |
| coil | output | 4 | Registered coil drive, {A,B,C,D} |

## Verification
The hardest case to reach is a mode change to full-step while the controller sits at a two-coil position. The direction then decides which neighbour it snaps to, and it must still happen while `coil` lags by one edge. The bench gets there by running half-step for an odd number of enabled edges and then clearing `half_step`, in both directions. It then runs a long pseudo-random sweep over every combination of enable, mode, direction and occasional reset, and compares each edge against an arithmetic position model.

// File: rtl/step_pkg.sv
package step_pkg;

    localparam int PHASES  = 4;
    localparam int SEQ_LEN = 2 * PHASES;
    localparam int IDX_W   = $clog2(SEQ_LEN);

    typedef logic [PHASES-1:0] phase_t;
    typedef logic [IDX_W-1:0]  pos_t;

    typedef enum logic [IDX_W:0] {
        ST_0   = 4'd0,
        ST_1   = 4'd1,
        ST_2   = 4'd2,
        ST_3   = 4'd3,
        ST_4   = 4'd4,
        ST_5   = 4'd5,
        ST_6   = 4'd6,
        ST_7   = 4'd7,
        ST_OFF = 4'd8
    } step_state_e;

    typedef struct packed {
        logic half;
        logic rev;
    } step_cmd_t;

    // Entry positions from the all-off state
    localparam pos_t ENTRY_FWD = pos_t'(0);
    localparam pos_t ENTRY_REV = pos_t'(SEQ_LEN - 2);

    function automatic step_state_e to_state(input pos_t p);
        return step_state_e'({1'b0, p});
    endfunction

    // Coil pattern for a state: even positions energise one coil,
    // odd positions energise that coil and the following one.
    function automatic phase_t phase_of(input step_state_e s);
        phase_t p;
        int     lead;
        int     trail;
        p = '0;
        if (s != ST_OFF) begin
            lead  = int'(s) / 2;
            trail = (lead + 1) % PHASES;
            p[PHASES-1-lead] = 1'b1;
            if (s[0]) begin
                p[PHASES-1-trail] = 1'b1;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/step_next.sv
module step_next
    import step_pkg::*;
(
    input  step_state_e cur,
    input  step_cmd_t   cmd,
    output step_state_e nxt
);

    pos_t pos;
    pos_t stride;
    pos_t fwd_pos;
    pos_t rev_pos;

    assign pos = cur[IDX_W-1:0];

    // Full-step from a two-coil position moves by one to land on a single coil
    always_comb begin
        if (cmd.half || pos[0]) begin
            stride = pos_t'(1);
        end else begin
            stride = pos_t'(2);
        end
    end

    assign fwd_pos = pos + stride;
    assign rev_pos = pos - stride;

    always_comb begin
        if (cur == ST_OFF) begin
            nxt = cmd.rev ? to_state(ENTRY_REV) : to_state(ENTRY_FWD);
        end else if (cmd.rev) begin
            nxt = to_state(rev_pos);
        end else begin
            nxt = to_state(fwd_pos);
        end
    end

endmodule

// File: rtl/step_phase_reg.sv
module step_phase_reg
    import step_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t d,
    output phase_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R9: never more than two coils driven at once
    a_r9_coil_count: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(q) <= 2))
        else $error("a_r9_coil_count");

    // R9: a pair of driven coils must be neighbours (ring order A,B,C,D)
    a_r9_coil_adjacent: assert property (@(posedge clk) disable iff (rst)
        ($countones(d) == 2) |=>
            (q == 4'b1100 || q == 4'b0110 || q == 4'b0011 || q == 4'b1001))
        else $error("a_r9_coil_adjacent");

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
    import step_pkg::*;
(
    input  logic       step_clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       half_step,
    input  logic       reverse,
    output logic [3:0] coil
);

    step_state_e state;
    step_state_e state_nxt;
    step_cmd_t   cmd;
    phase_t      phase_d;
    phase_t      phase_q;

    assign cmd.half = half_step;
    assign cmd.rev  = reverse;

    step_next u_next (
        .cur (state),
        .cmd (cmd),
        .nxt (state_nxt)
    );

    always_ff @(posedge step_clk) begin
        if (rst) begin
            state <= ST_OFF;
        end else if (enable) begin
            state <= state_nxt;
        end
    end

    assign phase_d = phase_of(state);

    step_phase_reg u_out (
        .clk (step_clk),
        .rst (rst),
        .d   (phase_d),
        .q   (phase_q)
    );

    assign coil = phase_q;

    // R2: disabled edges hold the position
    a_r2_hold: assert property (@(posedge step_clk) disable iff (rst)
        !enable |=> $stable(state))
        else $error("a_r2_hold");

    // R3, R4: every enabled half-step edge lands on a new energised position
    a_r3_moves: assert property (@(posedge step_clk) disable iff (rst)
        (enable && half_step) |=> (state != $past(state) && state != ST_OFF))
        else $error("a_r3_moves");

    // R5: full-step edges always land on a single-coil position
    a_r5_single_coil: assert property (@(posedge step_clk) disable iff (rst)
        (enable && !half_step) |=> (state != ST_OFF && !state[0]))
        else $error("a_r5_single_coil");

    // R7: once energised, stepping never returns to all-off
    a_r7_no_off: assert property (@(posedge step_clk) disable iff (rst)
        (state != ST_OFF) |=> (state != ST_OFF))
        else $error("a_r7_no_off");

endmodule

// File: tb/tb_step_sequencer.sv
module tb_step_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int OFF = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic       half_step;
    logic       reverse;
    logic [3:0] coil;

    int n_checks = 0;
    int n_fail   = 0;
    int ms       = OFF;
    logic [3:0] exp_coil = 4'b0000;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    step_sequencer dut (
        .step_clk  (clk),
        .rst       (rst),
        .enable    (enable),
        .half_step (half_step),
        .reverse   (reverse),
        .coil      (coil)
    );

    function automatic logic [3:0] pattern(input int s);
        logic [3:0] p;
        int c1;
        int c2;
        p = 4'b0000;
        if (s != OFF) begin
            c1 = s / 2;
            c2 = (c1 + 1) % 4;
            p[3 - c1] = 1'b1;
            if (s % 2 == 1) p[3 - c2] = 1'b1;
        end
        return p;
    endfunction

    function automatic int next_pos(input int s, input logic h, input logic r);
        if (s == OFF) return r ? 6 : 0;
        if (h) return r ? (s + 7) % 8 : (s + 1) % 8;
        if (s % 2 == 1) return r ? s - 1 : (s + 1) % 8;
        return r ? (s + 6) % 8 : (s + 2) % 8;
    endfunction

    task automatic check(input string tag);
        n_checks++;
        if (coil !== exp_coil) begin
            n_fail++;
            $display("FAIL %s: coil=%b expected=%b", tag, coil, exp_coil);
        end
    endtask

    // One step-clock edge: model follows, outputs sampled at the falling edge
    task automatic tick(input string tag);
        @(posedge clk);
        if (rst) begin
            exp_coil = 4'b0000;
            ms = OFF;
        end else begin
            exp_coil = pattern(ms);
            if (enable) ms = next_pos(ms, half_step, reverse);
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic set_in(input logic r, input logic e, input logic h, input logic d);
        rst = r; enable = e; half_step = h; reverse = d;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        set_in(1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        tick("R1 reset");
        tick("R1 reset");

        // R3 forward half-step, including the lag of R8 on the first edge
        set_in(1'b0, 1'b1, 1'b1, 1'b0);
        tick("R8 lag after entry");
        for (int i = 0; i < 10; i++) tick("R3 forward half-step");

        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        tick("R1 reset mid-run");
        tick("R1 reset mid-run");

        // R4 reverse half-step
        set_in(1'b0, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 11; i++) tick("R4 reverse half-step");

        // R2 hold
        set_in(1'b0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) tick("R2 enable low holds");

        // R5 full-step from reset, both directions
        set_in(1'b1, 1'b0, 1'b0, 1'b0);
        tick("R1 reset");
        set_in(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) tick("R5 full-step forward");
        set_in(1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) tick("R5 full-step reverse");
        set_in(1'b1, 1'b0, 1'b0, 1'b1);
        tick("R1 reset");
        set_in(1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) tick("R5 full-step reverse entry");

        // R6 snap from a two-coil position, forward then reverse
        set_in(1'b0, 1'b1, 1'b1, 1'b0);
        tick("R6 setup");
        set_in(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) tick("R6 snap forward");
        set_in(1'b0, 1'b1, 1'b1, 1'b1);
        tick("R6 setup");
        set_in(1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) tick("R6 snap reverse");

        // R7 direction flips mid-run
        set_in(1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) tick("R7 run forward");
        set_in(1'b0, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) tick("R7 flipped reverse");
        set_in(1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) tick("R7 flipped forward");

        // Pseudo-random sweep over all input combinations (R1..R9)
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            set_in(lfsr[4:0] == 5'd0, lfsr[6:5] != 2'b00, lfsr[7], lfsr[9]);
            if (rst)             tick("R1 sweep");
            else if (!enable)    tick("R2 sweep");
            else if (!half_step) tick("R5 R6 sweep");
            else if (reverse)    tick("R4 R7 sweep");
            else                 tick("R3 R8 sweep");
            if ($countones(coil) > 2) begin
                n_checks++;
                n_fail++;
                $display("FAIL R9: coil=%b expected=at most two bits", coil);
            end
        end

        finish_run();
    end

endmodule